// File: doc/BRIEF.md
# Decimating Capture Address Generator

This block produces the pixel write address and write strobe for a small frame buffer that holds a 64 x 64 capture window taken out of a much larger video field. A horizontal counter advances once per accepted pixel sample and forms the low six address bits. Each time it completes a 64-sample line, a line-skip counter advances. Only one line in every (skip + 1) is kept, and only a kept line can move the vertical part of the address. The result is a vertical zoom of 1:1, 1:2, 1:3 or 1:4.

Vertical panning uses a start value that is measured in kept lines. Before the start point, a pre-start counter counts kept lines. That counter is wider than the 6-bit vertical address, so the start point can lie well past line 63. When the count reaches the start value, capture begins with the vertical address at zero. Capture continues for 64 kept lines and then stops until the next field.

A processor programs the skip and start values through a small register write port. Both values are held in shadow registers and are copied into the working set only at a field boundary. This lets software reprogram them at any point in a field, including vertical retrace, without disturbing the field in progress.

Top module: `capture_addr_gen`

## Requirements
- R1: After reset, wr_addr is 0 and wr_en is 0. The working skip value is 3 and the working start value is 0, so start_seen is 1 until the first field boundary.
- R2: wr_addr[5:0] increments on every cycle with smp_en high and line_start and field_start low. It wraps from 63 to 0, and that wrap marks the end of a line. line_start clears wr_addr[5:0], and it wins over smp_en in the same cycle.
- R3: With a working skip value k (0 to 3), a line is kept when its index since the field boundary, taken mod (k+1), equals k. wr_addr[11:6] changes only at the end of a kept line, or at a field boundary.
- R4: start_seen is high once the number of kept lines completed in the field reaches the working start value (0 to 511). The first kept line after that point is written with wr_addr[11:6] = 0.
- R5: wr_en is high only in a cycle with smp_en high, line_start and field_start low, start_seen high, the current line kept, and capture not yet finished. The address shown in that cycle is the one to write.
- R6: After 64 kept lines have been written, wr_en stays low until the next field_start.
- R7: field_start clears the horizontal, line-skip, pre-start and vertical counters, and resets the start and finish state. No write happens in that cycle.
- R8: A register write with cfg_we high sets the skip shadow (cfg_sel = 0, value in cfg_wdata[1:0]) or the start shadow (cfg_sel = 1, value in cfg_wdata[8:0]). The shadows become the working values only at the next field_start. A write in the same cycle as field_start applies only from the field after that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_en | input | 1 | One pixel sample is taken in this cycle |
| line_start | input | 1 | Start-of-line pulse from the horizontal timing logic |
| field_start | input | 1 | Field boundary pulse |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 = skip, 1 = start |
| cfg_wdata | input | 9 | Register write data |
| wr_addr | output | 12 | Buffer address: {vertical[5:0], horizontal[5:0]} |
| wr_en | output | 1 | Buffer write strobe |
| start_seen | output | 1 | The start line has been reached in this field |

## Verification
The bench covers four areas.

- **Line selection.** Runs use every skip value and start values of 0, small, and past 63. A design that kept the wrong line of each group, or began one line early or late, writes rows under the wrong vertical address.
- **End of capture.** A field that runs past 64 kept lines checks that capture ends cleanly. A design without the finish state would overwrite row 0.
- **Register timing.** Register writes are made mid-field and in the same cycle as a field boundary. A design that applied them at once would change line decimation within a field.
- **Short lines.** A line is cut short by line_start. A design that let the sample win in that cycle, or counted the cut line, would write a stray pixel or misplace the next row.

// File: rtl/cag_pkg.sv
package cag_pkg;
    // Register selector used on the configuration port
    typedef enum logic {
        CFG_SKIP  = 1'b0,
        CFG_START = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/cag_cfg_regs.sv
module cag_cfg_regs
    import cag_pkg::*;
#(
    parameter int SKIP_W   = 2,
    parameter int START_W  = 9,
    parameter int SKIP_RST = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [START_W-1:0] cfg_wdata,
    input  logic               field_start,
    output logic [SKIP_W-1:0]  skip_act,
    output logic [START_W-1:0] start_act
);
    typedef struct packed {
        logic [SKIP_W-1:0]  skip_sh;
        logic [START_W-1:0] start_sh;
        logic [SKIP_W-1:0]  skip_act;
        logic [START_W-1:0] start_act;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // working set takes the shadows as they stood before this cycle
        if (field_start) begin
            st_d.skip_act  = st_q.skip_sh;
            st_d.start_act = st_q.start_sh;
        end
        if (cfg_we) begin
            if (cfg_sel_e'(cfg_sel) == CFG_SKIP)
                st_d.skip_sh = cfg_wdata[SKIP_W-1:0];
            else
                st_d.start_sh = cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.skip_sh   <= SKIP_W'(SKIP_RST);
            st_q.start_sh  <= '0;
            st_q.skip_act  <= SKIP_W'(SKIP_RST);
            st_q.start_act <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign skip_act  = st_q.skip_act;
    assign start_act = st_q.start_act;
endmodule

// File: rtl/cag_line_ctr.sv
module cag_line_ctr #(
    parameter int H_BITS = 6,
    parameter int SKIP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_en,
    input  logic              line_start,
    input  logic              field_start,
    input  logic [SKIP_W-1:0] skip_act,
    output logic [H_BITS-1:0] hcnt,
    output logic              kept_line,
    output logic              line_end
);
    localparam logic [H_BITS-1:0] H_LAST = {H_BITS{1'b1}};

    typedef struct packed {
        logic [H_BITS-1:0] hcnt;
        logic [SKIP_W-1:0] skcnt;
    } line_state_t;

    line_state_t st_d, st_q;
    logic        take;

    always_comb begin
        st_d     = st_q;
        take     = smp_en && !line_start && !field_start;
        line_end = take && (st_q.hcnt == H_LAST);
        if (field_start || line_start) begin
            st_d.hcnt = '0;
        end else if (smp_en) begin
            st_d.hcnt = st_q.hcnt + 1'b1;
        end
        if (field_start) begin
            st_d.skcnt = '0;
        end else if (line_end) begin
            st_d.skcnt = (st_q.skcnt == skip_act) ? '0 : st_q.skcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hcnt      = st_q.hcnt;
    assign kept_line = (st_q.skcnt == skip_act);
endmodule

// File: rtl/cag_vert_ctr.sv
module cag_vert_ctr #(
    parameter int V_BITS = 6,
    parameter int V_EXT  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     field_start,
    input  logic                     line_end,
    input  logic                     kept_line,
    input  logic [V_BITS+V_EXT-1:0]  start_act,
    output logic [V_BITS-1:0]        vaddr,
    output logic                     active,
    output logic                     done
);
    localparam int PRE_W = V_BITS + V_EXT;
    localparam logic [V_BITS-1:0] V_LAST = {V_BITS{1'b1}};

    typedef struct packed {
        logic [PRE_W-1:0]  vpre;
        logic [V_BITS-1:0] vaddr;
        logic              started;
        logic              done;
    } vert_state_t;

    vert_state_t st_d, st_q;
    logic        step;

    always_comb begin
        st_d   = st_q;
        active = st_q.started || (st_q.vpre == start_act);
        step   = line_end && kept_line;
        if (field_start) begin
            st_d = '0;
        end else begin
            st_d.started = active;
            if (step) begin
                if (!active) begin
                    st_d.vpre = st_q.vpre + 1'b1;
                end else if (!st_q.done) begin
                    st_d.vaddr = st_q.vaddr + 1'b1;
                    if (st_q.vaddr == V_LAST) st_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vaddr = st_q.vaddr;
    assign done  = st_q.done;
endmodule

// File: rtl/capture_addr_gen.sv
module capture_addr_gen #(
    parameter int H_BITS       = 6,
    parameter int V_BITS       = 6,
    parameter int V_EXT        = 3,
    parameter int SKIP_W       = 2,
    parameter int SKIP_DEFAULT = 3,
    localparam int ADDR_W      = H_BITS + V_BITS,
    localparam int START_W     = V_BITS + V_EXT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_en,
    input  logic               line_start,
    input  logic               field_start,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [START_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic               wr_en,
    output logic               start_seen
);
    logic [SKIP_W-1:0]  skip_act;
    logic [START_W-1:0] start_act;
    logic [H_BITS-1:0]  hcnt;
    logic [V_BITS-1:0]  vaddr;
    logic               kept_line, line_end, active, done;

    cag_cfg_regs #(.SKIP_W(SKIP_W), .START_W(START_W), .SKIP_RST(SKIP_DEFAULT)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .field_start(field_start),
        .skip_act(skip_act), .start_act(start_act)
    );

    cag_line_ctr #(.H_BITS(H_BITS), .SKIP_W(SKIP_W)) u_line (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .line_start(line_start),
        .field_start(field_start), .skip_act(skip_act),
        .hcnt(hcnt), .kept_line(kept_line), .line_end(line_end)
    );

    cag_vert_ctr #(.V_BITS(V_BITS), .V_EXT(V_EXT)) u_vert (
        .clk(clk), .rst_n(rst_n), .field_start(field_start),
        .line_end(line_end), .kept_line(kept_line), .start_act(start_act),
        .vaddr(vaddr), .active(active), .done(done)
    );

    assign wr_addr    = {vaddr, hcnt};
    assign start_seen = active;
    assign wr_en      = smp_en && !line_start && !field_start && active && !done && kept_line;
endmodule

// File: rtl/capture_addr_gen_checker.sv
module capture_addr_gen_checker #(
    parameter int H_BITS = 6,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_en,
    input logic              line_start,
    input logic              field_start,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_en,
    input logic              start_seen
);
    a_r2_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> wr_addr[H_BITS-1:0] == '0);

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_en && !line_start && !field_start) |=> $stable(wr_addr[H_BITS-1:0]));

    a_r3_vstep_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(wr_addr[ADDR_W-1:H_BITS]) && !$past(field_start))
        |-> ($past(wr_addr[H_BITS-1:0]) == {H_BITS{1'b1}} && $past(smp_en)));

    a_r5_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (start_seen && smp_en && !line_start && !field_start));

    a_r6_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == {ADDR_W{1'b1}}) |=> !wr_en);

    a_r7_field_clear: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> wr_addr == '0);
endmodule

bind capture_addr_gen capture_addr_gen_checker #(.H_BITS(H_BITS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .line_start(line_start),
    .field_start(field_start), .wr_addr(wr_addr), .wr_en(wr_en),
    .start_seen(start_seen)
);

// File: tb/capture_addr_gen_bench.sv
module capture_addr_gen_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        smp_en = 0, line_start = 0, field_start = 0;
    logic        cfg_we = 0, cfg_sel = 0;
    logic [8:0]  cfg_wdata = '0;
    logic [11:0] wr_addr;
    logic        wr_en, start_seen;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [11:0] exp_q[$];

    always #10 clk = ~clk;  // 50 MHz

    capture_addr_gen u_capture_addr_gen (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .line_start(line_start),
        .field_start(field_start), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .wr_addr(wr_addr), .wr_en(wr_en),
        .start_seen(start_seen)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor: every write must match the next expected address (R5)
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (exp_q.size() == 0) begin
                check(0, "R5 unexpected write", int'(wr_addr), -1);
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                check(wr_addr == e, "R5 write address", int'(wr_addr), int'(e));
            end
        end
    end

    task automatic cyc(input bit s, input bit ls, input bit fs);
        smp_en = s; line_start = ls; field_start = fs;
        @(posedge clk); #1;
        smp_en = 0; line_start = 0; field_start = 0; cfg_we = 0;
    endtask

    task automatic cfg_write(input bit sel, input int data);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = 9'(data);
        cyc(0, 0, 0);
    endtask

    // one field: k and st are the working values expected for it (R3, R4, R6)
    task automatic run_field(input int k, input int st, input int nlines, input bit gaps,
                             input bit cfg_on, input bit csel, input int cdata);
        if (cfg_on) begin cfg_we = 1; cfg_sel = csel; cfg_wdata = 9'(cdata); end
        cyc(0, 0, 1);
        check(wr_addr == 0, "R7 address cleared", int'(wr_addr), 0);
        for (int L = 0; L < nlines; L++) begin
            int kept_done;
            bit kept;
            int kidx;
            cyc(0, 1, 0);
            kept_done = L / (k + 1);
            check(start_seen == (kept_done >= st), "R4 start_seen", int'(start_seen),
                  int'(kept_done >= st));
            kept = ((L % (k + 1)) == k);
            kidx = L / (k + 1);
            for (int h = 0; h < 64; h++) begin
                if (kept && kidx >= st && (kidx - st) < 64)
                    exp_q.push_back(12'(((kidx - st) << 6) | h));
                cyc(1, 0, 0);
                if (gaps && (h % 5 == 0)) cyc(0, 0, 0);
            end
            cyc(0, 0, 0);
        end
        cyc(0, 0, 0);
        check(exp_q.size() == 0, "R6 all expected writes seen", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(wr_addr == 0, "R1 reset address", int'(wr_addr), 0);
        check(wr_en == 0, "R1 reset write strobe", int'(wr_en), 0);
        rst_n = 1;
        @(posedge clk); #1;
        check(start_seen == 1, "R1 default start 0", int'(start_seen), 1);

        // R3 default skip 3: every fourth line
        run_field(3, 0, 20, 0, 0, 0, 0);

        // R8 skip 0, start 2
        cfg_write(0, 0);
        cfg_write(1, 2);
        run_field(0, 2, 10, 0, 0, 0, 0);

        // R3 skip 1, start 1, with sample gaps (R2 hold)
        cfg_write(0, 1);
        cfg_write(1, 1);
        run_field(1, 1, 12, 1, 0, 0, 0);

        // R6 capture stops after 64 rows
        cfg_write(0, 0);
        cfg_write(1, 0);
        run_field(0, 0, 70, 0, 0, 0, 0);

        // R4 start beyond row 63
        cfg_write(1, 70);
        run_field(0, 70, 75, 0, 0, 0, 0);

        // R8 write in the same cycle as field_start applies only one field later
        run_field(0, 70, 5, 0, 1, 1, 1);
        // R8 mid-field write: must not change the current field
        fork
            run_field(0, 1, 4, 0, 0, 0, 0);
            begin
                repeat (100) @(posedge clk);
                #2 cfg_we = 1; cfg_sel = 0; cfg_wdata = 9'd3;
            end
        join
        run_field(3, 1, 12, 0, 0, 0, 0);

        // R2 line_start clears the horizontal count and beats smp_en
        cfg_write(0, 0);
        cfg_write(1, 0);
        cyc(0, 0, 1);
        cyc(0, 1, 0);
        for (int h = 0; h < 10; h++) begin
            exp_q.push_back(12'(h));
            cyc(1, 0, 0);
        end
        check(wr_addr[5:0] == 10, "R2 count advance", int'(wr_addr[5:0]), 10);
        smp_en = 1; line_start = 1;
        #8;
        check(wr_en == 0, "R2 line_start beats sample", int'(wr_en), 0);
        @(posedge clk); #1;
        smp_en = 0; line_start = 0;
        check(wr_addr[5:0] == 0, "R2 line_start clear", int'(wr_addr[5:0]), 0);
        check(wr_addr[11:6] == 0, "R3 short line no row step", int'(wr_addr[11:6]), 0);
        for (int h = 0; h < 64; h++) begin
            exp_q.push_back(12'(h));
            cyc(1, 0, 0);
        end
        check(wr_addr[11:6] == 1, "R3 row step after full line", int'(wr_addr[11:6]), 1);
        cyc(0, 0, 0);
        check(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule